// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit. It combines the rounding and mode controls, the five exception-enable bits, the result-class field and a set of sticky exception flags. Three derived summary bits are kept consistent with those flags: the invalid-operation summary, the enabled-exception summary and the overall exception summary.

The register is changed in three ways. A full-register write loads a new word, but the block discards the two derived summary bits it carries and recomputes them from the new contents. A raise request carries a mask of flags to set. The mask is ORed into the word, and the exception summary is set when the request turns on at least one flag that was previously clear. A fraction-inexact update loads the fraction-inexact bit. When the update value is 1 it first raises the inexact exception through the same raise path. All changes take effect on the clock edge after the request. A full write wins over any raise or fraction-inexact update in the same cycle.

Top module: `fpscr_reg`

## Requirements
- R1: After reset, `reg_q` is 0x00000000 and `fx_o`, `fex_o` and `vx_o` are 0.
- R2: A full write (`wr_en`=1) loads `wr_data` into every bit except bit 30 (enabled summary) and bit 29 (invalid summary). The written values of those two bits are ignored. This includes rounding mode bits 1..0, the non-IEEE bit 2 and the result-class field bits 16..12.
- R3: After a full write, bit 29 is 1 exactly when at least one of the nine invalid sub-flags is 1. The sub-flags are bits 24..19 and bits 10..8, mask 0x01F80700.
- R4: After a full write, bit 30 is 1 exactly when (bits 29..25 AND bits 7..3) is nonzero. Bit 29 in this term is the value recomputed under R3. The exception group is invalid, overflow, underflow, zero-divide and inexact. The enable group is invalid, overflow, underflow, zero-divide and inexact.
- R5: A raise request (`raise_en`=1) ORs `raise_mask` into the register. No bit is cleared by a raise.
- R6: On a raise, bit 31 is set when the effective mask contains a bit that was 0 beforehand. Otherwise bit 31 keeps its value.
- R7: After a raise, bits 29 and 30 are set when the R3 and R4 conditions hold on the new contents. They are never cleared except by a full write.
- R8: A fraction-inexact update (`fi_en`=1) with `fi_val`=1 adds the inexact flag, bit 25, to the effective raise mask under R5 to R7, and sets bit 17. With `fi_val`=0 it clears only bit 17. The update is applied after any raise in the same cycle.
- R9: When `wr_en` is 1, `raise_en` and `fi_en` in the same cycle have no effect. The result is the R2 to R4 write result.
- R10: `fx_o`, `fex_o` and `vx_o` always equal bits 31, 30 and 29 of `reg_q`.
- R11: With no request active, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Full-register write request |
| wr_data | input | 32 | Word for full write |
| raise_en | input | 1 | Exception raise request |
| raise_mask | input | 32 | Flags to set on a raise |
| fi_en | input | 1 | Fraction-inexact update request |
| fi_val | input | 1 | New fraction-inexact value |
| reg_q | output | 32 | Register contents |
| fx_o | output | 1 | Exception summary |
| fex_o | output | 1 | Enabled-exception summary |
| vx_o | output | 1 | Invalid-operation summary |

## Verification
Several rules hold on every cycle and are checked that way. A raise never clears a bit. The invalid summary is set whenever a sub-flag is present. Both summaries match their formulas after a full write. A raise that adds a new flag sets the exception summary, and an idle cycle leaves the word unchanged. Other behaviours show only in the bench's scenarios. These are the exact bit-for-bit word after each write across all enable and exception combinations, and the precedence of a write over a simultaneous raise. They also include the ordering of the fraction-inexact update against a raise, and the case where a repeated raise leaves the exception summary untouched.

// File: rtl/fpscr_pkg.sv
`timescale 1ns/1ps
package fpscr_pkg;
  localparam int W        = 32;
  localparam int B_FX     = 31;
  localparam int B_FEX    = 30;
  localparam int B_VX     = 29;
  localparam int B_XX     = 25;
  localparam int B_FI     = 17;
  localparam int GRP_W    = 5;
  localparam int EXC_LO   = 25;
  localparam int EN_LO    = 3;
  localparam int N_SUB    = 9;
  localparam int unsigned SUB_POS [N_SUB] = '{24, 23, 22, 21, 20, 19, 10, 9, 8};
  localparam logic [W-1:0] SUM_MASK = (W'(1) << B_FEX) | (W'(1) << B_VX);
endpackage

// File: rtl/fpscr_rst_sync.sv
`timescale 1ns/1ps
module fpscr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fpscr_summary.sv
`timescale 1ns/1ps
module fpscr_summary
  import fpscr_pkg::*;
(
  input  logic [W-1:0] base_i,
  output logic [W-1:0] val_o
);
  logic [N_SUB-1:0] sub_hit;
  logic             vx_new;
  logic [GRP_W-1:0] exc_grp;
  logic [GRP_W-1:0] en_grp;
  logic             fex_new;

  genvar g;
  generate
    for (g = 0; g < N_SUB; g++) begin : g_sub
      assign sub_hit[g] = base_i[SUB_POS[g]];
    end
  endgenerate

  always_comb begin
    // invalid summary first, then the enabled summary uses it
    vx_new  = base_i[B_VX] | (|sub_hit);
    exc_grp = base_i[EXC_LO +: GRP_W];
    exc_grp[GRP_W-1] = vx_new;
    en_grp  = base_i[EN_LO +: GRP_W];
    fex_new = base_i[B_FEX] | (|(exc_grp & en_grp));
    val_o          = base_i;
    val_o[B_VX]    = vx_new;
    val_o[B_FEX]   = fex_new;
  end
endmodule

// File: rtl/fpscr_next.sv
`timescale 1ns/1ps
module fpscr_next
  import fpscr_pkg::*;
(
  input  logic [W-1:0] cur_i,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         raise_en,
  input  logic [W-1:0] raise_mask,
  input  logic         fi_en,
  input  logic         fi_val,
  output logic [W-1:0] nxt_o,
  output logic         load_o
);
  logic [W-1:0] eff_mask;
  logic [W-1:0] raised;
  logic [W-1:0] base;
  logic         new_bit;

  always_comb begin
    eff_mask = raise_en ? raise_mask : '0;
    if (fi_en && fi_val) eff_mask[B_XX] = 1'b1;
    new_bit = |(eff_mask & ~cur_i);
    raised  = cur_i | eff_mask;
    if (new_bit) raised[B_FX] = 1'b1;
    if (fi_en)   raised[B_FI] = fi_val;
    base    = wr_en ? (wr_data & ~SUM_MASK) : raised;
    load_o  = wr_en | raise_en | fi_en;
  end

  fpscr_summary u_sum (
    .base_i (base),
    .val_o  (nxt_o)
  );
endmodule

// File: rtl/fpscr_reg.sv
`timescale 1ns/1ps
module fpscr_reg
  import fpscr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [31:0]  wr_data,
  input  logic         raise_en,
  input  logic [31:0]  raise_mask,
  input  logic         fi_en,
  input  logic         fi_val,
  output logic [31:0]  reg_q,
  output logic         fx_o,
  output logic         fex_o,
  output logic         vx_o
);
  logic         rst_sync_n;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         load;

  fpscr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpscr_next u_next (
    .cur_i      (state_q),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .raise_en   (raise_en),
    .raise_mask (raise_mask),
    .fi_en      (fi_en),
    .fi_val     (fi_val),
    .nxt_o      (state_d),
    .load_o     (load)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  state_q <= '0;
    else if (load)    state_q <= state_d;
  end

  assign reg_q = state_q;
  assign fx_o  = state_q[B_FX];
  assign fex_o = state_q[B_FEX];
  assign vx_o  = state_q[B_VX];

  // R5
  raise_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (raise_en && !wr_en) |=> ((reg_q & $past(reg_q)) == $past(reg_q)));

  // R5
  raise_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (raise_en && !wr_en && !fi_en) |=> ((reg_q & $past(raise_mask)) == $past(raise_mask)));

  // R3
  vx_after_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> (vx_o == (|(reg_q & 32'h01F8_0700))));

  // R3
  vx_covers_subs_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(reg_q & 32'h01F8_0700)) |-> vx_o);

  // R4
  fex_after_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> (fex_o == (|(reg_q[29:25] & reg_q[7:3]))));

  // R6
  fx_on_new_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (raise_en && !wr_en && ((reg_q & raise_mask) != raise_mask)) |=> fx_o);

  // R7
  summary_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && (vx_o || fex_o)) |=> ((vx_o || !$past(vx_o)) && (fex_o || !$past(fex_o))));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && !raise_en && !fi_en) |=> $stable(reg_q));
endmodule

// File: tb/fpscr_reg_tb.sv
`timescale 1ns/1ps
module fpscr_reg_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        raise_en;
  logic [31:0] raise_mask;
  logic        fi_en;
  logic        fi_val;
  logic [31:0] reg_q;
  logic        fx_o, fex_o, vx_o;

  int n_checks;
  int n_fail;
  bit done;
  logic [31:0] model;

  localparam logic [31:0] SUBS = 32'h01F8_0700;

  fpscr_reg dut_i (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_data (wr_data),
    .raise_en (raise_en), .raise_mask (raise_mask),
    .fi_en (fi_en), .fi_val (fi_val),
    .reg_q (reg_q), .fx_o (fx_o), .fex_o (fex_o), .vx_o (vx_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] summ(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    if ((r & SUBS) != 0) r = r | 32'h2000_0000;
    if ((((r >> 25) & (r >> 3)) & 32'h1F) != 0) r = r | 32'h4000_0000;
    return r;
  endfunction

  function automatic logic [31:0] m_write(input logic [31:0] d);
    return summ(d & 32'h9FFF_FFFF);
  endfunction

  function automatic logic [31:0] m_upd(input logic [31:0] cur, input logic re,
                                        input logic [31:0] m, input logic fe, input logic fv);
    logic [31:0] e;
    logic [31:0] r;
    e = re ? m : 32'h0;
    if (fe && fv) e = e | 32'h0200_0000;
    r = cur | e;
    if ((cur & e) != e) r = r | 32'h8000_0000;
    if (fe) r = fv ? (r | 32'h0002_0000) : (r & ~32'h0002_0000);
    return summ(r);
  endfunction

  task automatic check(input string tag, input logic [31:0] exp);
    n_checks++;
    if (reg_q !== exp || fx_o !== exp[31] || fex_o !== exp[30] || vx_o !== exp[29]) begin
      n_fail++;
      $display("FAIL %s: actual reg=%08h fx=%b fex=%b vx=%b expected reg=%08h",
               tag, reg_q, fx_o, fex_o, vx_o, exp);
    end
  endtask

  // drive at a negedge, posedge latches, sample at the following negedge
  task automatic op(input logic we, input logic [31:0] wd, input logic re,
                    input logic [31:0] rm, input logic fe, input logic fv);
    wr_en = we; wr_data = wd; raise_en = re; raise_mask = rm; fi_en = fe; fi_val = fv;
    @(negedge clk);
    wr_en = 1'b0; raise_en = 1'b0; fi_en = 1'b0; fi_val = 1'b0;
    wr_data = 32'h0; raise_mask = 32'h0;
    if (we) model = m_write(wd);
    else if (re || fe) model = m_upd(model, re, rm, fe, fv);
  endtask

  task automatic wr(input logic [31:0] d);
    op(1'b1, d, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic rs(input logic [31:0] m);
    op(1'b0, 32'h0, 1'b1, m, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0; model = 32'h0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_data = 32'h0; raise_en = 1'b0; raise_mask = 32'h0;
    fi_en = 1'b0; fi_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", 32'h0);

    // R2 R3 R4: enables x exceptions sweep, written summary bits forced on
    for (int e = 0; e < 32; e++) begin
      for (int x = 0; x < 32; x++) begin
        logic [31:0] d;
        d = (32'(x & 15) << 25) | (32'(e) << 3) | 32'h6001_5006;
        if (x[4]) d = d | 32'h0100_0000;
        wr(d);
        check("R4 write enable/exception sweep", model);
      end
    end

    // R3: each invalid sub-flag alone
    for (int i = 0; i < 32; i++) begin
      wr(32'h1 << i);
      check("R3 single bit write", model);
    end

    // R2: control fields pass through, rounding/non-IEEE/result class
    wr(32'h0001_F007);
    check("R2 control fields", 32'h0001_F007);

    // R5 R6 R7: raise each bit from a fixed base
    for (int i = 0; i < 32; i++) begin
      wr(32'h0000_0048);
      rs(32'h1 << i);
      check("R5 R6 single bit raise", model);
    end

    // R6: raising already-set bits leaves FX clear
    wr(32'h0400_0010);
    rs(32'h0400_0000);
    check("R6 repeat raise no FX", model);
    rs(32'h1000_0000);
    check("R6 new flag sets FX", model);

    // R7: summaries stay set through raises, clear only by write
    wr(32'h1000_0040);
    rs(32'h0080_0000);
    check("R7 raise invalid sub-flag", model);
    rs(32'h0000_0001);
    check("R7 sticky summaries", model);
    wr(32'h0);
    check("R7 write clears summaries", 32'h0);

    // R8: fraction-inexact update
    wr(32'h0000_0008);
    op(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    check("R8 fi=1 raises inexact", model);
    op(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    check("R8 fi=0 clears only FI", model);
    op(1'b0, 32'h0, 1'b1, 32'h0002_0001, 1'b1, 1'b0);
    check("R8 fi applied after raise", model);

    // R9: write wins over raise and fi in same cycle
    wr(32'h0);
    op(1'b1, 32'h0000_0002, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1);
    check("R9 write precedence", 32'h0000_0002);

    // R11: idle hold
    wr(32'h8123_4567);
    repeat (5) @(negedge clk);
    check("R11 idle hold", model);
    check("R10 summary outputs", m_write(32'h8123_4567));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule